// File: doc/BRIEF.md
# External Interrupt Sensitivity Controller

This block watches three groups of general-purpose input pins and turns selected pin events into two independent interrupt requests. Each request is held in a sticky pending flag that stays set until the CPU acknowledges it. Each request has its own 2-bit sensitivity field. The field chooses among four triggers:

- a falling edge;
- a rising edge;
- either edge;
- a falling edge combined with a low level, in which the request is raised again for as long as a pin stays low.

A single routing input decides which request serves the third pin group. A per-pin enable mask selects which pins take part at all.

Every pin passes through a two-flop synchronizer. Edges are found by comparing each synchronized sample with the one taken a clock earlier. The sensitivity register is guarded: a write takes effect only while both CPU interrupt-mask inputs are high. A write at any other time is dropped, and a sticky error flag records it.

When a write is accepted, edge detection is suppressed for one cycle. The first cycle under the new setting therefore cannot report an edge that was really seen under the old one.

Top module: `extint_sense_ctrl`

## Requirements
- R1: After reset both pending flags are 0, the sensitivity register reads 4'b1010 (falling edge for both requests), and the guard error flag is 0.
- R2: Sensitivity code 2'b10 (falling edge) sets the pending flag exactly three rising clock edges after an enabled pin of that request goes low. The flag is visible after the third edge and not after the second. A rising edge has no effect in this code.
- R3: Sensitivity code 2'b01 (rising edge) sets the pending flag on a low-to-high pin transition only, with the same three-edge latency.
- R4: Sensitivity code 2'b11 (both edges) sets the pending flag on either transition.
- R5: Sensitivity code 2'b00 sets the pending flag on a falling edge. It also sets the flag again on every clock while any enabled pin of that request is low, so an acknowledge given during the low level leaves the flag set.
- R6: Group A (grpAIn) always feeds request 0 and group B (grpBIn) always feeds request 1. Group C (grpCIn) feeds request 1 when routeSel is 0 and request 0 when routeSel is 1.
- R7: A pin whose bit in pinIntEn is 0 never affects either request. Bit layout of pinIntEn: group A in the low bits, then group B, then group C in the top bits.
- R8: A pending flag stays set until a one-cycle pulse on its ackReq bit (bit 0 for request 0, bit 1 for request 1). The flag reads 0 after the clock edge that samples the pulse.
- R9: If a new event for a request is sampled on the same clock edge as its acknowledge, the pending flag stays set.
- R10: A sensitivity write (senseWrEn) is accepted only when intMasked is 2'b11. Otherwise senseCfg keeps its value and wrGuardErr becomes 1. wrGuardErr is cleared only by reset.
- R11: In the first cycle after an accepted sensitivity write, no edge is reported for either request. An edge that would be sampled in that cycle is lost.
- R12: senseCfg bits [1:0] hold the request 0 code and bits [3:2] hold the request 1 code. The two requests are decoded independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| grpAIn | input | GRPA_W | Pin group A, always routed to request 0 |
| grpBIn | input | GRPB_W | Pin group B, always routed to request 1 |
| grpCIn | input | GRPC_W | Pin group C, routed by routeSel |
| pinIntEn | input | PIN_W | Per-pin enable, layout {C, B, A} |
| routeSel | input | 1 | 0: group C feeds request 1; 1: group C feeds request 0 |
| intMasked | input | 2 | CPU interrupt-mask bits; writes need both high |
| senseWrEn | input | 1 | Sensitivity write strobe |
| senseWrData | input | 4 | New sensitivity value, [1:0] request 0, [3:2] request 1 |
| ackReq | input | 2 | Per-request acknowledge pulse |
| irqPending | output | 2 | Sticky pending flags, bit 0 = request 0 |
| senseCfg | output | 4 | Current sensitivity register |
| wrGuardErr | output | 1 | Sticky flag for a dropped sensitivity write |

## Verification
Two pairs of functions can land on the same clock edge.

**Acknowledge and new event.** An acknowledge can arrive on the edge that samples a new event. The bench sets a flag, then drops a second pin so that its synchronized edge meets the acknowledge pulse, and expects the flag to survive. The low-level mode provokes the same overlap continuously, because every acknowledge meets a live event.

**Accepted write and edge.** An accepted sensitivity write can meet an edge arriving from the synchronizer. The bench times a pin fall two cycles ahead of the write strobe and expects the pending flag to stay clear. A later edge must still be reported normally.

// File: rtl/extint_pkg.sv
package extint_pkg;

  localparam int NSRC = 2;
  localparam int MODE_W = 2;
  localparam int CFG_W = NSRC * MODE_W;

  typedef enum logic [MODE_W-1:0] {
    SENSE_FALL_LOW = 2'b00,
    SENSE_RISE     = 2'b01,
    SENSE_FALL     = 2'b10,
    SENSE_BOTH     = 2'b11
  } senseMode_t;

  localparam logic [CFG_W-1:0] CFG_RESET = {SENSE_FALL, SENSE_FALL};

  typedef struct packed {
    logic            cfgFresh;
    logic [NSRC-1:0] ackClr;
  } dpStrobe_t;

endpackage

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       intMasked,
  input  logic             senseWrEn,
  input  logic [CFG_W-1:0] senseWrData,
  input  logic [NSRC-1:0]  ackReq,
  output logic [CFG_W-1:0] senseCfg,
  output logic             wrGuardErr,
  output dpStrobe_t        strobe
);

  logic       fullyMasked;
  logic       wrAccept;
  logic       wrReject;
  logic       freshQ;
  logic       pastValid;

  assign fullyMasked = &intMasked;
  assign wrAccept    = senseWrEn & fullyMasked;
  assign wrReject    = senseWrEn & ~fullyMasked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      senseCfg   <= CFG_RESET;
      wrGuardErr <= 1'b0;
      freshQ     <= 1'b0;
      pastValid  <= 1'b0;
    end else begin
      pastValid <= 1'b1;
      freshQ    <= wrAccept;
      if (wrAccept) senseCfg <= senseWrData;
      if (wrReject) wrGuardErr <= 1'b1;
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.cfgFresh = freshQ;
    strobe.ackClr   = ackReq;
  end

  // R10: the register only moves on a guarded, fully masked write
  assert_cfg_guarded_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pastValid && $past(!(senseWrEn && (&intMasked)))) |-> $stable(senseCfg));

  // R10: a dropped write leaves the error flag raised
  assert_guard_err_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pastValid && $past(senseWrEn && !(&intMasked))) |-> wrGuardErr);

  // R10: the error flag never falls outside reset
  assert_guard_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pastValid && $past(wrGuardErr)) |-> wrGuardErr);

endmodule

// File: rtl/extint_datapath.sv
module extint_datapath
  import extint_pkg::*;
#(
  parameter int GRPA_W = 8,
  parameter int GRPB_W = 8,
  parameter int GRPC_W = 6,
  localparam int PIN_W = GRPA_W + GRPB_W + GRPC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GRPA_W-1:0] grpAIn,
  input  logic [GRPB_W-1:0] grpBIn,
  input  logic [GRPC_W-1:0] grpCIn,
  input  logic [PIN_W-1:0] pinIntEn,
  input  logic             routeSel,
  input  logic [CFG_W-1:0] senseCfg,
  input  dpStrobe_t        strobe,
  output logic [NSRC-1:0]  irqPending
);

  localparam int SYNC_STAGES = 2;

  logic [PIN_W-1:0] rawPins;
  logic [PIN_W-1:0] syncStage [SYNC_STAGES];
  logic [PIN_W-1:0] syncNow;
  logic [PIN_W-1:0] syncPrev;
  logic [PIN_W-1:0] srcMask [NSRC];
  logic [NSRC-1:0]  srcEvent;
  logic [NSRC-1:0]  edgeOnly;
  logic             pastValid;

  assign rawPins = {grpCIn, grpBIn, grpAIn};

  // pin synchronizer and one-sample history
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncStage[i] <= '1;
      syncPrev  <= '1;
      pastValid <= 1'b0;
    end else begin
      syncStage[0] <= rawPins;
      for (int i = 1; i < SYNC_STAGES; i++) syncStage[i] <= syncStage[i-1];
      syncPrev  <= syncStage[SYNC_STAGES-1];
      pastValid <= 1'b1;
    end
  end

  assign syncNow = syncStage[SYNC_STAGES-1];

  // group routing: A to source 0, B to source 1, C by routeSel
  always_comb begin
    srcMask[0] = {{GRPC_W{routeSel}},  {GRPB_W{1'b0}}, {GRPA_W{1'b1}}} & pinIntEn;
    srcMask[1] = {{GRPC_W{~routeSel}}, {GRPB_W{1'b1}}, {GRPA_W{1'b0}}} & pinIntEn;
  end

  genvar s;
  generate
    for (s = 0; s < NSRC; s++) begin : g_src
      senseMode_t mode;
      logic anyFall;
      logic anyRise;
      logic anyLow;
      logic edgeHit;
      logic pendQ;

      assign mode    = senseMode_t'(senseCfg[s*MODE_W +: MODE_W]);
      assign anyFall = |(syncPrev & ~syncNow & srcMask[s]);
      assign anyRise = |(~syncPrev & syncNow & srcMask[s]);
      assign anyLow  = |(~syncNow & srcMask[s]);

      always_comb begin
        unique case (mode)
          SENSE_FALL_LOW: edgeHit = anyFall;
          SENSE_RISE:     edgeHit = anyRise;
          SENSE_FALL:     edgeHit = anyFall;
          SENSE_BOTH:     edgeHit = anyFall | anyRise;
          default:        edgeHit = 1'b0;
        endcase
      end

      assign edgeOnly[s] = edgeHit & ~strobe.cfgFresh;
      assign srcEvent[s] = edgeOnly[s] | ((mode == SENSE_FALL_LOW) & anyLow);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pendQ <= 1'b0;
        else        pendQ <= srcEvent[s] | (pendQ & ~strobe.ackClr[s]);
      end

      assign irqPending[s] = pendQ;

      // R8: an event is always latched into the pending flag
      assert_event_latched_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pastValid && $past(srcEvent[s])) |-> irqPending[s]);

      // R8: an acknowledge without a competing event clears the flag
      assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pastValid && $past(strobe.ackClr[s] && !srcEvent[s])) |-> !irqPending[s]);

      // R9: with an event present, the acknowledge cannot clear the flag
      assert_event_beats_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pastValid && $past(strobe.ackClr[s] && srcEvent[s])) |-> irqPending[s]);

      // R11: pure edge modes report nothing in the first cycle after a write
      assert_no_fresh_edge_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe.cfgFresh && mode != SENSE_FALL_LOW) |-> !srcEvent[s]);
    end
  endgenerate

endmodule

// File: rtl/extint_sense_ctrl.sv
module extint_sense_ctrl
  import extint_pkg::*;
#(
  parameter int GRPA_W = 8,
  parameter int GRPB_W = 8,
  parameter int GRPC_W = 6,
  localparam int PIN_W = GRPA_W + GRPB_W + GRPC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GRPA_W-1:0] grpAIn,
  input  logic [GRPB_W-1:0] grpBIn,
  input  logic [GRPC_W-1:0] grpCIn,
  input  logic [PIN_W-1:0]  pinIntEn,
  input  logic              routeSel,
  input  logic [1:0]        intMasked,
  input  logic              senseWrEn,
  input  logic [3:0]        senseWrData,
  input  logic [1:0]        ackReq,
  output logic [1:0]        irqPending,
  output logic [3:0]        senseCfg,
  output logic              wrGuardErr
);

  dpStrobe_t strobe;

  extint_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .intMasked   (intMasked),
    .senseWrEn   (senseWrEn),
    .senseWrData (senseWrData),
    .ackReq      (ackReq),
    .senseCfg    (senseCfg),
    .wrGuardErr  (wrGuardErr),
    .strobe      (strobe)
  );

  extint_datapath #(
    .GRPA_W (GRPA_W),
    .GRPB_W (GRPB_W),
    .GRPC_W (GRPC_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .grpAIn     (grpAIn),
    .grpBIn     (grpBIn),
    .grpCIn     (grpCIn),
    .pinIntEn   (pinIntEn),
    .routeSel   (routeSel),
    .senseCfg   (senseCfg),
    .strobe     (strobe),
    .irqPending (irqPending)
  );

endmodule

// File: tb/extint_sense_ctrl_tb.sv
module extint_sense_ctrl_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  grpAIn = '1;
  logic [7:0]  grpBIn = '1;
  logic [5:0]  grpCIn = '1;
  logic [21:0] pinIntEn = '0;
  logic        routeSel = 1'b0;
  logic [1:0]  intMasked = 2'b11;
  logic        senseWrEn = 1'b0;
  logic [3:0]  senseWrData = '0;
  logic [1:0]  ackReq = '0;
  logic [1:0]  irqPending;
  logic [3:0]  senseCfg;
  logic        wrGuardErr;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    string      tag;
    logic [1:0] pend;
    logic [3:0] cfg;
    logic       err;
  } expItem_t;

  expItem_t scoreQ[$];
  logic [3:0] curCfg = 4'b1010;
  logic       curErr = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  extint_sense_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .grpAIn(grpAIn), .grpBIn(grpBIn), .grpCIn(grpCIn),
    .pinIntEn(pinIntEn), .routeSel(routeSel), .intMasked(intMasked),
    .senseWrEn(senseWrEn), .senseWrData(senseWrData), .ackReq(ackReq),
    .irqPending(irqPending), .senseCfg(senseCfg), .wrGuardErr(wrGuardErr)
  );

  // monitor: compares queued expectations against registered outputs
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (scoreQ.size() > 0) begin
        expItem_t it;
        it = scoreQ.pop_front();
        total++;
        if (irqPending !== it.pend || senseCfg !== it.cfg || wrGuardErr !== it.err) begin
          bad++;
          $display("FAIL %s: got pend=%b cfg=%b err=%b, expected pend=%b cfg=%b err=%b",
                   it.tag, irqPending, senseCfg, wrGuardErr, it.pend, it.cfg, it.err);
        end
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectNow(string tag, logic [1:0] pend);
    expItem_t it;
    it.tag = tag; it.pend = pend; it.cfg = curCfg; it.err = curErr;
    scoreQ.push_back(it);
  endtask

  task automatic ack(logic [1:0] which);
    ackReq = which;
    tick(1);
    ackReq = '0;
  endtask

  task automatic writeCfg(logic [3:0] val, logic [1:0] mask);
    intMasked = mask;
    senseWrEn = 1'b1;
    senseWrData = val;
    tick(1);
    senseWrEn = 1'b0;
    intMasked = 2'b11;
    if (&mask) curCfg = val;
    else curErr = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    expectNow("R1 reset state", 2'b00);
    rst_n = 1'b1;
    pinIntEn = '1;
    tick(4);
    expectNow("R1 quiet after reset", 2'b00);

    // R2 falling edge on group A
    grpAIn[3] = 1'b0;
    tick(2); expectNow("R2 not before third edge", 2'b00);
    tick(1); expectNow("R2 falling sets ei0", 2'b01);
    tick(2); expectNow("R8 sticky without ack", 2'b01);
    ack(2'b01); expectNow("R8 ack clears", 2'b00);
    grpAIn[3] = 1'b1;
    tick(4); expectNow("R2 rising ignored", 2'b00);

    // R6 routing of group C
    routeSel = 1'b0;
    grpCIn[2] = 1'b0;
    tick(3); expectNow("R6 C to ei1 when routeSel=0", 2'b10);
    ack(2'b10);
    grpCIn[2] = 1'b1;
    tick(4);
    routeSel = 1'b1;
    tick(1);
    grpCIn[2] = 1'b0;
    tick(3); expectNow("R6 C to ei0 when routeSel=1", 2'b01);
    ack(2'b01);
    grpCIn[2] = 1'b1;
    tick(4);
    grpBIn[6] = 1'b0;
    tick(3); expectNow("R6 B to ei1", 2'b10);
    ack(2'b10);
    grpBIn[6] = 1'b1;
    tick(4);

    // R7 disabled pin
    pinIntEn[8] = 1'b0;
    grpBIn[0] = 1'b0;
    tick(5); expectNow("R7 disabled pin ignored", 2'b00);
    grpBIn[0] = 1'b1;
    tick(4);
    pinIntEn[8] = 1'b1;
    tick(1);

    // R10 guarded write
    writeCfg(4'b0101, 2'b01);
    expectNow("R10 write dropped, error set", 2'b00);
    writeCfg(4'b0101, 2'b11);
    expectNow("R10 accepted write, error sticky", 2'b00);
    tick(2);

    // R3 rising edge mode
    grpAIn[1] = 1'b0;
    tick(4); expectNow("R3 falling ignored", 2'b00);
    grpAIn[1] = 1'b1;
    tick(3); expectNow("R3 rising sets ei0", 2'b01);
    ack(2'b01);
    tick(2);

    // R12 independent fields: ei0 rising, ei1 falling
    writeCfg(4'b1001, 2'b11);
    tick(2);
    grpBIn[5] = 1'b0;
    grpAIn[5] = 1'b0;
    tick(4); expectNow("R12 ei1 falls, ei0 ignores fall", 2'b10);
    ack(2'b10);
    grpBIn[5] = 1'b1;
    grpAIn[5] = 1'b1;
    tick(4); expectNow("R12 ei0 rises, ei1 ignores rise", 2'b01);
    ack(2'b01);
    tick(2);

    // R4 both edges
    writeCfg(4'b1111, 2'b11);
    tick(2);
    grpAIn[2] = 1'b0;
    tick(3); expectNow("R4 fall in both mode", 2'b01);
    ack(2'b01);
    grpAIn[2] = 1'b1;
    tick(3); expectNow("R4 rise in both mode", 2'b01);
    ack(2'b01);
    tick(2);

    // R9 event coincides with acknowledge
    grpAIn[6] = 1'b0;
    tick(3); expectNow("R9 first flag set", 2'b01);
    grpAIn[4] = 1'b0;
    tick(2);
    ack(2'b01);
    expectNow("R9 event wins over ack", 2'b01);
    tick(1); expectNow("R9 flag still held", 2'b01);
    ack(2'b01); expectNow("R9 later ack clears", 2'b00);
    grpAIn[6] = 1'b1;
    grpAIn[4] = 1'b1;
    tick(3);
    ack(2'b01);
    tick(2);

    // R11 edge lost in first cycle after accepted write
    grpAIn[0] = 1'b0;
    tick(1);
    writeCfg(4'b1111, 2'b11);
    tick(3); expectNow("R11 edge after write suppressed", 2'b00);
    grpAIn[0] = 1'b1;
    tick(3); expectNow("R11 next edge reported", 2'b01);
    ack(2'b01);
    tick(2);

    // R5 falling edge and low level
    writeCfg(4'b0000, 2'b11);
    tick(2); expectNow("R5 all high, quiet", 2'b00);
    grpAIn[7] = 1'b0;
    tick(3); expectNow("R5 low sets ei0", 2'b01);
    ack(2'b01); expectNow("R5 low level re-raises after ack", 2'b01);
    tick(3);
    ack(2'b01); expectNow("R5 still raised while low", 2'b01);
    grpAIn[7] = 1'b1;
    tick(3);
    ack(2'b01); expectNow("R5 clears once high", 2'b00);

    tick(3);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule